// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block picks the source of each ALU operand for the instruction in the execute stage of a five-stage load/store pipeline. It compares the two source register numbers of that instruction with the destination register numbers of the two older instructions still in flight. One of these is in the memory stage and the other is in the write-back stage. A match counts only when the older instruction will really write its destination.

For each operand the block drives a 2-bit select code. It also drives the value that the code picks: the register-file read, the memory-stage ALU result, or the write-back value. When both downstream stages hold a matching producer, the memory stage wins, because it holds the most recent one. An instruction three places behind its producer needs no bypass, since the register file writes early in the cycle and reads late in the cycle.

The block is purely combinational and has no clock. Stall generation, the register file and the ALU sit outside it.

Top module: `fwd_unit`

## Requirements
- R1: When neither downstream stage qualifies for an operand, its select is 2'b00 and the operand equals its register-file read value.
- R2: When the memory stage has its write enable high, a non-zero destination, and that destination equals the operand's source register, the select is 2'b10 and the operand equals the memory-stage result.
- R3: When the memory stage does not qualify but the write-back stage has its write enable high, a non-zero destination, and that destination equals the source, the select is 2'b01 and the operand equals the write-back value.
- R4: When both stages qualify for the same source, the memory stage takes priority and the select is 2'b10.
- R5: A stage whose write enable is low never supplies an operand, whatever its destination is.
- R6: A destination of register 0 never supplies an operand, even with its write enable high.
- R7: Operand A depends only on the execute-stage Rs and operand B only on Rt. A match on one source does not change the other operand's select.
- R8: The select code 2'b11 is never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | ADDR_W | First source register of the execute-stage instruction |
| ex_rt | input | ADDR_W | Second source register of the execute-stage instruction |
| mem_rd | input | ADDR_W | Destination register held in the memory stage |
| mem_we | input | 1 | Register-write enable of the memory-stage instruction |
| wb_rd | input | ADDR_W | Destination register held in the write-back stage |
| wb_we | input | 1 | Register-write enable of the write-back-stage instruction |
| rf_a | input | DATA_W | Register-file read value for Rs |
| rf_b | input | DATA_W | Register-file read value for Rt |
| mem_result | input | DATA_W | ALU result held in the memory stage |
| wb_value | input | DATA_W | Value being written back in the write-back stage |
| sel_a | output | 2 | Select code for operand A |
| sel_b | output | 2 | Select code for operand B |
| op_a | output | DATA_W | Chosen first ALU operand |
| op_b | output | DATA_W | Chosen second ALU operand |

## Verification
Whenever the inputs settle, the embedded assertions check four things. No select is 2'b11. A stage is chosen only when its write enable is high and its destination is non-zero. Each operand carries the value its code names. The priority of the memory stage over the write-back stage, and the independence of the two operands, depend on which stages match. Only the bench shows these: it sweeps every relation between the two sources and the two destinations, with every pair of write enables, and compares the results with a model built from the requirements.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;
  localparam int NUM_OPERANDS = 2;
endpackage

// File: rtl/fwd_select.sv
module fwd_select #(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] mem_rd,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] wb_rd,
  input  logic              wb_we,
  output logic [1:0]        sel
);
  import fwd_pkg::*;

  localparam logic [ADDR_W-1:0] ZERO_REG = '0;

  logic mem_hit;
  logic wb_hit;
  fwd_sel_e code;

  // A producer qualifies only if it writes a real register equal to our source
  assign mem_hit = mem_we && (mem_rd != ZERO_REG) && (mem_rd == src);
  assign wb_hit  = wb_we  && (wb_rd  != ZERO_REG) && (wb_rd  == src);

  // Nearer stage first: it holds the newest value
  always_comb begin
    if (mem_hit)     code = SEL_MEM;
    else if (wb_hit) code = SEL_WB;
    else             code = SEL_RF;
  end

  assign sel = code;

  always_comb begin
    assert_no_code3_R8: assert (sel != 2'b11);
    if (sel == SEL_MEM) begin
      assert_mem_enabled_R5: assert (mem_we);
      assert_mem_nonzero_R6: assert (mem_rd != ZERO_REG);
    end
    if (sel == SEL_WB) begin
      assert_wb_enabled_R5: assert (wb_we);
      assert_wb_nonzero_R6: assert (wb_rd != ZERO_REG);
    end
  end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] mem_val,
  input  logic [DATA_W-1:0] wb_val,
  output logic [DATA_W-1:0] out
);
  import fwd_pkg::*;

  always_comb begin
    case (sel)
      SEL_MEM: out = mem_val;
      SEL_WB:  out = wb_val;
      default: out = rf_val;
    endcase
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] ex_rs,
  input  logic [ADDR_W-1:0] ex_rt,
  input  logic [ADDR_W-1:0] mem_rd,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] wb_rd,
  input  logic              wb_we,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic [DATA_W-1:0] mem_result,
  input  logic [DATA_W-1:0] wb_value,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b
);
  import fwd_pkg::*;

  localparam int N = NUM_OPERANDS;

  logic [N-1:0][ADDR_W-1:0] src_vec;
  logic [N-1:0][DATA_W-1:0] rf_vec;
  logic [N-1:0][1:0]        sel_vec;
  logic [N-1:0][DATA_W-1:0] op_vec;

  assign src_vec[0] = ex_rs;
  assign src_vec[1] = ex_rt;
  assign rf_vec[0]  = rf_a;
  assign rf_vec[1]  = rf_b;

  for (genvar i = 0; i < N; i++) begin : g_operand
    fwd_select #(.ADDR_W(ADDR_W)) u_sel (
      .src    (src_vec[i]),
      .mem_rd (mem_rd),
      .mem_we (mem_we),
      .wb_rd  (wb_rd),
      .wb_we  (wb_we),
      .sel    (sel_vec[i])
    );
    fwd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel     (sel_vec[i]),
      .rf_val  (rf_vec[i]),
      .mem_val (mem_result),
      .wb_val  (wb_value),
      .out     (op_vec[i])
    );

    always_comb begin
      if (sel_vec[i] == SEL_RF)  assert_rf_pass_R1:  assert (op_vec[i] == rf_vec[i]);
      if (sel_vec[i] == SEL_MEM) assert_mem_pass_R2: assert (op_vec[i] == mem_result);
      if (sel_vec[i] == SEL_WB)  assert_wb_pass_R3:  assert (op_vec[i] == wb_value);
    end
  end

  assign sel_a = sel_vec[0];
  assign sel_b = sel_vec[1];
  assign op_a  = op_vec[0];
  assign op_b  = op_vec[1];
endmodule

// File: tb/test_fwd_unit.sv
module test_fwd_unit;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] VA  = 32'hAAAA_0001;
  localparam logic [DATA_W-1:0] VB  = 32'hBBBB_0002;
  localparam logic [DATA_W-1:0] VM  = 32'hCCCC_0003;
  localparam logic [DATA_W-1:0] VW  = 32'hDDDD_0004;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [ADDR_W-1:0] ex_rs, ex_rt, mem_rd, wb_rd;
  logic mem_we, wb_we;
  logic [DATA_W-1:0] rf_a, rf_b, mem_result, wb_value;
  logic [1:0] sel_a, sel_b;
  logic [DATA_W-1:0] op_a, op_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  fwd_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fwd_unit (
    .ex_rs(ex_rs), .ex_rt(ex_rt), .mem_rd(mem_rd), .mem_we(mem_we),
    .wb_rd(wb_rd), .wb_we(wb_we), .rf_a(rf_a), .rf_b(rf_b),
    .mem_result(mem_result), .wb_value(wb_value),
    .sel_a(sel_a), .sel_b(sel_b), .op_a(op_a), .op_b(op_b)
  );

  function automatic logic [1:0] model_sel(logic [ADDR_W-1:0] s);
    if (mem_we && mem_rd != 0 && mem_rd == s) return 2'b10;
    if (wb_we && wb_rd != 0 && wb_rd == s)    return 2'b01;
    return 2'b00;
  endfunction

  function automatic string req_tag(logic [ADDR_W-1:0] s);
    logic mm, wm;
    mm = (mem_rd == s);
    wm = (wb_rd == s);
    if (mm && wm && mem_we && wb_we && s != 0) return "R4";
    if ((mm && mem_rd == 0) || (wm && wb_rd == 0)) return "R6";
    if ((mm && !mem_we) || (wm && !wb_we)) return "R5";
    if (mm) return "R2";
    if (wm) return "R3";
    return "R1";
  endfunction

  task automatic check(string req, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (rs=%0d rt=%0d mrd=%0d mwe=%0d wrd=%0d wwe=%0d)",
               req, what, act, exp, ex_rs, ex_rt, mem_rd, mem_we, wb_rd, wb_we);
    end
  endtask

  function automatic logic [DATA_W-1:0] val_of(logic [1:0] sel, logic [DATA_W-1:0] rf);
    case (sel)
      2'b10:   return VM;
      2'b01:   return VW;
      default: return rf;
    endcase
  endfunction

  task automatic apply_and_check();
    logic [1:0] ea, eb;
    @(posedge clk);
    #1;
    ea = model_sel(ex_rs);
    eb = model_sel(ex_rt);
    @(negedge clk);
    check(req_tag(ex_rs), "sel_a", {30'd0, sel_a}, {30'd0, ea});
    check(req_tag(ex_rt), "sel_b", {30'd0, sel_b}, {30'd0, eb});
    check(req_tag(ex_rs), "op_a", op_a, val_of(ea, VA));
    check(req_tag(ex_rt), "op_b", op_b, val_of(eb, VB));
    check("R8", "sel_a code", {31'd0, sel_a == 2'b11}, 32'd0);
    check("R8", "sel_b code", {31'd0, sel_b == 2'b11}, 32'd0);
  endtask

  initial begin
    rf_a = VA; rf_b = VB; mem_result = VM; wb_value = VW;
    ex_rs = '0; ex_rt = '0; mem_rd = '0; wb_rd = '0; mem_we = 0; wb_we = 0;
    // Idle state: nothing forwarded (R1)
    @(negedge clk);
    check("R1", "idle sel_a", {30'd0, sel_a}, 32'd0);
    check("R1", "idle op_b", op_b, VB);

    // R7: a match on Rt only leaves operand A on the register file
    ex_rs = 5'd3; ex_rt = 5'd9; mem_rd = 5'd9; mem_we = 1; wb_rd = 5'd7; wb_we = 1;
    @(negedge clk);
    check("R7", "sel_a isolated", {30'd0, sel_a}, 32'd0);
    check("R7", "sel_b mem", {30'd0, sel_b}, 32'd2);
    check("R7", "op_a isolated", op_a, VA);

    // Full-width register numbers at the top of the range
    ex_rs = 5'd31; ex_rt = 5'd31; mem_rd = 5'd30; wb_rd = 5'd31; mem_we = 1; wb_we = 1;
    @(negedge clk);
    check("R3", "high reg sel_a", {30'd0, sel_a}, 32'd1);
    check("R3", "high reg op_b", op_b, VW);

    // Exhaustive sweep over register numbers 0..3 and all enables
    for (int rs = 0; rs < 4; rs++)
      for (int rt = 0; rt < 4; rt++)
        for (int md = 0; md < 4; md++)
          for (int wd = 0; wd < 4; wd++)
            for (int en = 0; en < 4; en++) begin
              ex_rs = rs[ADDR_W-1:0]; ex_rt = rt[ADDR_W-1:0];
              mem_rd = md[ADDR_W-1:0]; wb_rd = wd[ADDR_W-1:0];
              mem_we = en[1]; wb_we = en[0];
              apply_and_check();
            end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule